// File: doc/BRIEF.md
# Clock-Enable Divider with Cross-Domain Divisor Handoff

This block turns a fast free-running clock into a one-cycle enable pulse, `tick`, that repeats once every `divisor + 1` fast cycles. Logic in the fast domain uses the pulse as a clock enable, so that it advances at a programmable bit rate without a derived clock. The divisor is an 8-bit value owned by a slower system clock domain. The two clocks need not be related, but the fast clock must be at least as fast as the system clock.

The divisor crosses domains through a periodic sample-and-mark scheme. The system side captures the divisor at a fixed cadence and raises a flag while the captured copy is stable. The fast side copies the value only while the synchronized flag is high. In the fast domain the count runs in a down-counter built from 2-bit segments with registered borrows. Terminal count is found through a two-stage registered detect, which keeps every next-state function narrow. Divisors 0 and 1 are too short for that detect latency, so they bypass the counter through a small toggle path.

Top module: `tick_divider`

## Requirements
- R1: While `rst` is high, `tick` is 0 at every fast-clock edge after the first one.
- R2: With a settled divisor D of 2 or more, `tick` is high for exactly one fast cycle, and consecutive pulses are exactly D+1 fast cycles apart (a pulse gap equal to D+1, with `tick` low in between).
- R3: With a settled divisor of 0, `tick` is high in every fast cycle.
- R4: With a settled divisor of 1, `tick` alternates high and low on successive fast cycles.
- R5: The system domain samples `divisor` once every six system cycles. It holds a safe flag high for two system cycles and low for four. The fast domain updates its divisor copy only while the two-stage synchronized flag is high. After `divisor` changes and is held 60 fast cycles, a pulse follows within 400 more fast cycles, and from that pulse onward the R2 to R4 spacing holds for the new value.
- R6: The counter is made of four 2-bit segments, where each upper segment decrements by a registered borrow from the segments below. The terminal detect registers "low four bits equal 2" and "upper four bits equal 0" separately, and a pulse follows one cycle after both hold. A pulse reloads the counter from the divisor copy and clears the borrow and detect registers. The result is exact spacing across segment borrows, for example with D = 17 and D = 255.
- R7: A reset applied asynchronously reaches the fast domain through a synchronizer, and its release is synchronous. On reset the fast divisor copy is 0, so the block pulses every cycle until the first handoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; `divisor` is sampled on it |
| fast_clk | input | 1 | Fast clock; `tick` is registered on it |
| rst | input | 1 | Active-high reset, synchronous to `sys_clk`, asserted asynchronously into the fast domain |
| divisor | input | 8 | Pulse spacing minus one, in fast cycles |
| tick | output | 1 | One-fast-cycle enable pulse |

## Verification
Two functions can meet in the same fast cycle. One is the copy of a freshly handed-off divisor during the safe window. The other is a pulse that reloads the counter, or a switch between the small-divisor toggle path and the counted path. The bench provokes these meetings by changing `divisor` at arbitrary points in a running count. The changes go across the small/large boundary and across segment wraps (1 to 17, 255 to 1, 17 to 0). A behavioural gap model is re-armed on the first pulse after the handoff window, and from then on it predicts `tick` in every fast cycle. A stray pulse or a missing pulse is flagged in the cycle where it happens.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;
  // Default divisor width and counter segmentation.
  parameter int unsigned TD_DIV_W  = 8;
  parameter int unsigned TD_SEG_W  = 2;
  // Width of the system-side sampling cadence counter.
  parameter int unsigned TD_HOLD_W = 2;
endpackage

// File: rtl/td_sync2.sv
// Two-stage synchronizer with asynchronous reset to a chosen value.
module td_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/td_div_latch.sv
// System-domain sampler: captures the divisor on a fixed cadence and marks
// the interval during which the captured copy may be taken by the fast side.
module td_div_latch import tickdiv_pkg::*; #(
  parameter int unsigned DIV_W  = TD_DIV_W,
  parameter int unsigned HOLD_W = TD_HOLD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] lat_div,
  output logic             lat_norm,
  output logic             safe
);
  logic [HOLD_W-1:0] hold_q;
  logic              safe_q;
  logic [DIV_W-1:0]  lat_div_q;
  logic              lat_norm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      safe_q     <= 1'b0;
      lat_div_q  <= '0;
      lat_norm_q <= 1'b0;
    end else begin
      hold_q <= hold_q - HOLD_W'(1);
      if (hold_q == '0) begin
        if (!safe_q) begin
          // capture point: flag goes up for two cycles
          safe_q     <= 1'b1;
          hold_q     <= HOLD_W'(1);
          lat_div_q  <= div_in;
          lat_norm_q <= |div_in[DIV_W-1:1];
        end else begin
          // drop the flag, keep the captured value
          safe_q <= 1'b0;
        end
      end
    end
  end

  assign lat_div  = lat_div_q;
  assign lat_norm = lat_norm_q;
  assign safe     = safe_q;

  // R5: flag stays up exactly two system cycles
  p_safe_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(safe_q) |=> (safe_q ##1 !safe_q));

  // R5: captured divisor does not move while the flag is held
  p_latch_held_r5: assert property (@(posedge clk) disable iff (rst)
    (safe_q && $past(safe_q)) |-> $stable(lat_div_q));
endmodule

// File: rtl/td_seg_counter.sv
// Fast-domain pulse generator: segmented down-counter with registered
// borrows, two-part registered terminal detect, and a bypass path for
// divisors below two.
module td_seg_counter import tickdiv_pkg::*; #(
  parameter int unsigned DIV_W = TD_DIV_W,
  parameter int unsigned SEG_W = TD_SEG_W
) (
  input  logic             clk,
  input  logic             frst,
  input  logic             safe_sync,
  input  logic [DIV_W-1:0] lat_div,
  input  logic             lat_norm,
  output logic             en
);
  localparam int unsigned NSEG = DIV_W / SEG_W;
  localparam int unsigned LO_W = 2 * SEG_W;

  logic [DIV_W-1:0] cnt_q, cnt_dec;
  logic [NSEG-2:0]  cy_q, cy_nx;
  logic [DIV_W-1:0] div_q;
  logic             norm_q;
  logic             dlo_q, dhi_q;
  logic             en_q, pre_q;
  logic             dlo_nx, dhi_nx;

  genvar s;
  generate
    for (s = 0; s < NSEG; s++) begin : g_seg
      if (s == 0) begin : g_low
        assign cnt_dec[SEG_W-1:0] = cnt_q[SEG_W-1:0] - SEG_W'(1);
        assign cy_nx[0] = (cnt_q[SEG_W-1:0] == '0);
      end else begin : g_up
        assign cnt_dec[s*SEG_W +: SEG_W] =
          cnt_q[s*SEG_W +: SEG_W] - {{(SEG_W-1){1'b0}}, cy_q[s-1]};
        if (s < NSEG - 1) begin : g_cy
          assign cy_nx[s] = cy_q[s-1] & (cnt_q[s*SEG_W +: SEG_W] == '0);
        end
      end
    end
  endgenerate

  assign dlo_nx = (cnt_q[LO_W-1:0] == LO_W'(2));
  assign dhi_nx = (cnt_q[DIV_W-1:LO_W] == '0);

  always_ff @(posedge clk) begin
    if (frst) begin
      en_q   <= 1'b0;
      pre_q  <= 1'b1;
      cnt_q  <= '0;
      cy_q   <= '0;
      dlo_q  <= 1'b0;
      dhi_q  <= 1'b0;
      div_q  <= '0;
      norm_q <= 1'b0;
    end else begin
      en_q  <= (dlo_q & dhi_q) | pre_q;
      pre_q <= ~norm_q & (~pre_q | ~div_q[0]);
      if (en_q) begin
        cnt_q <= div_q;
        cy_q  <= '0;
        dlo_q <= 1'b0;
        dhi_q <= 1'b0;
      end else begin
        cnt_q <= cnt_dec;
        cy_q  <= cy_nx;
        dlo_q <= dlo_nx;
        dhi_q <= dhi_nx;
      end
      if (safe_sync) begin
        div_q  <= lat_div;
        norm_q <= lat_norm;
      end
    end
  end

  assign en = en_q;

  // R6: both detect halves set -> pulse on the following cycle
  p_detect_fires_r6: assert property (@(posedge clk) disable iff (frst)
    (dlo_q && dhi_q) |=> en_q);

  // R3: the bypass register drives a pulse one cycle later
  p_bypass_fires_r3: assert property (@(posedge clk) disable iff (frst)
    pre_q |=> en_q);

  // R4: with divisor 1 the bypass register toggles
  p_bypass_toggle_r4: assert property (@(posedge clk) disable iff (frst)
    (pre_q && div_q[0] && !norm_q) |=> !pre_q);

  // R2: bypass is silent for divisors of two or more
  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (frst)
    norm_q |=> !pre_q);

  // R5: fast copy changes only after a synchronized safe flag
  p_copy_gated_r5: assert property (@(posedge clk) disable iff (frst)
    (!$past(safe_sync) && !$past(frst)) |-> $stable(div_q));
endmodule

// File: rtl/tick_divider.sv
// Top: system-side sampler, synchronizers, fast-side pulse generator.
module tick_divider import tickdiv_pkg::*; #(
  parameter int unsigned DIV_W  = TD_DIV_W,
  parameter int unsigned SEG_W  = TD_SEG_W,
  parameter int unsigned HOLD_W = TD_HOLD_W
) (
  input  logic             sys_clk,
  input  logic             fast_clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] lat_div;
  logic             lat_norm;
  logic             safe;
  logic             safe_sync;
  logic             frst;

  td_div_latch #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_latch (
    .clk      (sys_clk),
    .rst      (rst),
    .div_in   (divisor),
    .lat_div  (lat_div),
    .lat_norm (lat_norm),
    .safe     (safe)
  );

  // R7: reset enters the fast domain asynchronously, leaves synchronously
  td_sync2 #(.RST_VAL(1'b1)) u_rst_sync (
    .clk  (fast_clk),
    .arst (rst),
    .d    (1'b0),
    .q    (frst)
  );

  td_sync2 #(.RST_VAL(1'b0)) u_safe_sync (
    .clk  (fast_clk),
    .arst (rst),
    .d    (safe),
    .q    (safe_sync)
  );

  td_seg_counter #(.DIV_W(DIV_W), .SEG_W(SEG_W)) u_count (
    .clk       (fast_clk),
    .frst      (frst),
    .safe_sync (safe_sync),
    .lat_div   (lat_div),
    .lat_norm  (lat_norm),
    .en        (tick)
  );
endmodule

// File: tb/tick_divider_test.sv
module tick_divider_test;
  localparam int FAST_PERIOD = 4;
  localparam int SYS_PERIOD  = 10;
  localparam int SETTLE      = 60;
  localparam int LIMIT       = 400;

  logic       sys_clk  = 1'b0;
  logic       fast_clk = 1'b0;
  logic       rst      = 1'b0;
  logic [7:0] divisor  = 8'd0;
  logic       tick;

  int checks   = 0;
  int failures = 0;
  int phase    = 0;
  int cur_div  = 0;
  bit mon_on   = 1'b0;
  bit ended    = 1'b0;

  always #(FAST_PERIOD/2) fast_clk = ~fast_clk;
  always #(SYS_PERIOD/2)  sys_clk  = ~sys_clk;

  tick_divider uut (
    .sys_clk  (sys_clk),
    .fast_clk (fast_clk),
    .rst      (rst),
    .divisor  (divisor),
    .tick     (tick)
  );

  task automatic report_fail(input string req, input int act, input int exp);
    failures++;
    $display("FAIL %s actual=%0d expected=%0d (divisor %0d, t=%0t)", req, act, exp, cur_div, $time);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Behavioural reference: gap counter armed on the first pulse after the
  // handoff window, then predicting tick in every fast cycle.
  int  seen_phase = -1;
  int  waitc = 0;
  int  gap = 0;
  bit  armed = 1'b0;
  bit  lost = 1'b0;

  function automatic string tag_for(input int d);
    if (d == 0) return "R3";
    if (d == 1) return "R4";
    return "R2/R6";
  endfunction

  always @(negedge fast_clk) begin
    if (mon_on) begin
      if (phase != seen_phase) begin
        seen_phase = phase;
        waitc = 0;
        armed = 1'b0;
        lost  = 1'b0;
      end
      waitc++;
      if (armed) begin
        bit exp_tick;
        exp_tick = (gap == cur_div);
        checks++;
        if (tick !== exp_tick) report_fail(tag_for(cur_div), int'(tick), int'(exp_tick));
        if (tick === 1'b1) gap = 0;
        else gap++;
      end else if (waitc > SETTLE) begin
        if (tick === 1'b1) begin
          armed = 1'b1;
          gap = 0;
          checks++;  // R5: a pulse arrived after the handoff window
        end else if (waitc > SETTLE + LIMIT && !lost) begin
          lost = 1'b1;
          checks++;
          report_fail("R5", waitc, SETTLE + LIMIT);
        end
      end
    end
  end

  task automatic check_reset_low(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge fast_clk);
      checks++;
      if (tick !== 1'b0) report_fail("R1", int'(tick), 0);
    end
  endtask

  task automatic run_div(input int d);
    @(negedge sys_clk);
    divisor = d[7:0];
    cur_div = d;
    phase++;
    repeat (SETTLE + LIMIT + 8 * (d + 1) + 20) @(negedge fast_clk);
  endtask

  initial begin
    #1 rst = 1'b1;
    repeat (3) @(negedge sys_clk);
    check_reset_low(6);                  // R1
    @(negedge sys_clk) rst = 1'b0;
    // R7: right after release the copy is 0, so pulses every cycle
    repeat (4) @(negedge fast_clk);
    checks++;
    if (tick !== 1'b1) report_fail("R7", int'(tick), 1);
    mon_on = 1'b1;
    run_div(0);
    run_div(1);
    run_div(2);
    run_div(3);
    run_div(17);
    run_div(255);
    run_div(1);
    run_div(17);
    // reset in the middle of a count
    mon_on = 1'b0;
    @(negedge sys_clk) rst = 1'b1;
    repeat (3) @(negedge sys_clk);
    check_reset_low(5);                  // R1
    @(negedge sys_clk) rst = 1'b0;
    mon_on = 1'b1;
    phase++;
    repeat (SETTLE + LIMIT + 200) @(negedge fast_clk);
    run_div(0);
    run_div(3);
    run_div(2);
    finish_run();
  end

  initial begin
    #(FAST_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule